// File: doc/BRIEF.md
# Instruction Stream Hazard Checker

This block watches the instruction stream of an in-order shader core after scheduling and reports the first broken scheduling rule. Each instruction arrives already decoded into flags: its type (ALU or branch), whether each of the two ALU slots is active, whether its destination is a special unit and which unit class it targets, the load signals, the thread-switch signal, accumulator r4 use, and the texture-wait op. The checker tracks delay windows after branches and thread switches, the latency of special-function results, the pairing of thread switches that marks the final switch, and the bans on register writes at the end of the thread. When the stream is over, a one-cycle end strobe runs the whole-program checks.

Instructions come in on a valid/ready channel. The checker never applies back-pressure: `in_ready` is high in every cycle where `rst_n` is high. An instruction counts only in a cycle where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low change nothing, whatever the other inputs hold. Instruction indices start at 0 after reset and go up by one for each accepted instruction. The first violation sets a sticky flag and latches its code and index. Nothing but reset clears them.

Top module: `instr_hazard_checker`

## Requirements
- R1: `in_ready` is 1 whenever `rst_n` is 1. An input with `in_valid`=0 does not advance the index and cannot raise or suppress a violation.
- R2: A varying load that is followed at once by a plain uniform load or a plain alternate-uniform load raises code 1. The register-file-destination forms do not count for this rule.
- R3: A uniform-type load (plain or register-file form) next to an alternate-uniform-type load (either form) raises code 2, in either order.
- R4: Let d be the current index minus the index of the last special-function write. If d < 2, then an r4 read raises code 5, an r4 write raises code 6 and another special-function write raises code 7.
- R5: Count, over one instruction, the active ALU slots with a special destination of kind texture(1), special-function(2), vertex-memory(3), tile(4) or sync(5), plus the texture, tile, tile-uniform and vertex-memory load signals. A count above one raises code 8. Kind 0, or a slot that is not special, is not counted.
- R6: Inside a thread-switch window (current index minus recorded switch index < 3), a special-function write raises code 3 and a varying load raises code 4.
- R7: A thread switch inside a branch window (distance < 3) raises code 9. A branch inside a branch window raises code 14, and a branch inside a thread-switch window raises code 15.
- R8: A thread switch directly after a thread switch is the last-switch marker and does not open a window. A second marker raises code 10. Any other thread switch inside an open window raises code 11. Each non-marker switch records its index and is counted.
- R9: Any thread switch seen once the marker exists ends the program. From that switch up to two instructions after it, an active slot with a non-special destination, or the address-writing signal, raises code 12. The texture-wait op exactly two instructions after it raises code 13.
- R10: When the end strobe arrives, two or more counted switches without a marker raise code 16, and the absence of a program-end switch raises code 17.
- R11: While reset is held with `single_seg`=1, the checker starts with the marker already present, so the first thread switch ends the program.
- R12: Only the first violation is latched. If one instruction breaks several rules, the lowest code wins. An end-strobe violation latches the number of accepted instructions as its index.
- R13: After reset `err_flag`, `err_code` and `err_index` are 0. The recorded branch, switch and special-function indices start at -10, so the first instructions fall in no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_seg | input | 1 | Program has a single segment (sampled during reset) |
| in_valid | input | 1 | Instruction flags valid |
| in_ready | output | 1 | Checker accepts an instruction |
| instr_is_branch | input | 1 | 1 = branch, 0 = ALU instruction |
| add_active | input | 1 | Add slot carries an operation |
| add_magic | input | 1 | Add slot writes a special destination |
| add_kind | input | 3 | Add slot special unit kind (0 other, 1..5 as in R5) |
| mul_active | input | 1 | Mul slot carries an operation |
| mul_magic | input | 1 | Mul slot writes a special destination |
| mul_kind | input | 3 | Mul slot special unit kind |
| ld_unif | input | 1 | Uniform load |
| ld_unif_rf | input | 1 | Uniform load to register file |
| ld_unifa | input | 1 | Alternate uniform load |
| ld_unifa_rf | input | 1 | Alternate uniform load to register file |
| ld_vary | input | 1 | Varying load |
| ld_tex | input | 1 | Texture result load |
| ld_tile | input | 1 | Tile buffer load |
| ld_tile_u | input | 1 | Tile buffer uniform-config load |
| ld_vpm | input | 1 | Vertex memory load |
| sig_wr_addr | input | 1 | A signal writes a register address |
| thr_switch | input | 1 | Thread-switch signal |
| r4_read | input | 1 | Instruction reads accumulator r4 |
| r4_write | input | 1 | Instruction writes accumulator r4 |
| tmu_wait | input | 1 | Add slot holds the texture-wait op |
| end_valid | input | 1 | End-of-program strobe |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 5 | Code of the first violation |
| err_index | output | IDX_W | Index of the first violation |

## Verification
The distance rules are each tried over a sweep of gaps from zero to three filler instructions. This locates the exact edge of every window: branch, switch and special-function latency. Load adjacency is tried over every ordered pair of the four uniform-type loads and over a varying load followed by each of them. That separates the two load rules and the register-file forms. The unit-count rule takes a full cross of both slot kinds with each load signal, so any counted class dropped from the sum shows up. Switch sequences cover the marker, a double marker, a too-close switch, program end in single-segment and multi-segment programs, and the end-strobe outcomes, with idle cycles and several violations at once to show that the index holds and that the first error wins.

// File: rtl/ihc_pkg.sv
`timescale 1ns/1ps
package ihc_pkg;

  localparam int KIND_W     = 3;
  localparam int CODE_W     = 5;
  localparam int NUM_RULES  = 17;
  localparam int WIN_SLOTS  = 3;   // delay window length after branch / switch
  localparam int SFU_LAT    = 2;   // special-function result distance
  localparam int END_SLOTS  = 2;   // instructions after the program-end switch
  localparam int RESET_DIST = 10;  // recorded indices start this far back

  typedef enum logic [KIND_W-1:0] {
    KIND_OTHER = 3'd0,
    KIND_TEX   = 3'd1,
    KIND_SFU   = 3'd2,
    KIND_VPM   = 3'd3,
    KIND_TILE  = 3'd4,
    KIND_SYNC  = 3'd5
  } unit_kind_e;

  typedef enum logic [CODE_W-1:0] {
    E_NONE         = 5'd0,
    E_VARY_UNIF    = 5'd1,
    E_UNIF_MIX     = 5'd2,
    E_SFU_SWWIN    = 5'd3,
    E_VARY_SWWIN   = 5'd4,
    E_R4RD_EARLY   = 5'd5,
    E_R4WR_EARLY   = 5'd6,
    E_SFU_EARLY    = 5'd7,
    E_MULTI_UNIT   = 5'd8,
    E_SW_BRWIN     = 5'd9,
    E_DOUBLE_MARK  = 5'd10,
    E_SW_CLOSE     = 5'd11,
    E_RF_AFTER_END = 5'd12,
    E_WAIT_LAST    = 5'd13,
    E_BR_BRWIN     = 5'd14,
    E_BR_SWWIN     = 5'd15,
    E_NO_MARK      = 5'd16,
    E_NO_END       = 5'd17
  } err_code_e;

endpackage

// File: rtl/ihc_unit_count.sv
`timescale 1ns/1ps
module ihc_unit_count
  import ihc_pkg::*;
#(
  parameter int NUM_ALU = 2
) (
  input  logic [NUM_ALU-1:0]        op_act,
  input  logic [NUM_ALU-1:0]        op_magic,
  input  logic [NUM_ALU*KIND_W-1:0] op_kind,
  input  logic                      ld_tex,
  input  logic                      ld_tile,
  input  logic                      ld_tile_u,
  input  logic                      ld_vpm,
  output logic                      sfu_any,
  output logic                      multi_unit
);
  localparam int NUM_SRC = NUM_ALU + 4;
  localparam int CW      = $clog2(NUM_SRC + 1);

  logic [NUM_ALU-1:0] uses_unit;
  logic [NUM_ALU-1:0] uses_sfu;
  logic [CW-1:0]      total;

  for (genvar a = 0; a < NUM_ALU; a++) begin : g_slot
    logic [KIND_W-1:0] kind;
    logic              special;
    assign kind         = op_kind[a*KIND_W +: KIND_W];
    assign special      = op_act[a] & op_magic[a];
    assign uses_unit[a] = special && (kind >= KIND_W'(KIND_TEX)) && (kind <= KIND_W'(KIND_SYNC));
    assign uses_sfu[a]  = special && (kind == KIND_W'(KIND_SFU));
  end

  always_comb begin
    total = '0;
    for (int a = 0; a < NUM_ALU; a++) total = total + CW'(uses_unit[a]);
    total = total + CW'(ld_tex) + CW'(ld_tile) + CW'(ld_tile_u) + CW'(ld_vpm);
  end

  assign sfu_any    = |uses_sfu;
  assign multi_unit = total > CW'(1);

endmodule

// File: rtl/ihc_track.sv
`timescale 1ns/1ps
module ihc_track
  import ihc_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_seg,
  input  logic             acc,
  input  logic             is_alu,
  input  logic             is_branch,
  input  logic             thrsw,
  input  logic             sfu_any,
  input  logic             vary,
  input  logic             u_any,
  input  logic             a_any,
  output logic [IDX_W-1:0] cur_idx,
  output logic             in_br_win,
  output logic             in_sw_win,
  output logic             sfu_close,
  output logic             sw_consec,
  output logic             prev_vary,
  output logic             prev_u,
  output logic             prev_a,
  output logic             last_found,
  output logic             thrend,
  output logic             end_win,
  output logic             end_last,
  output logic [1:0]       sw_cnt
);
  localparam int DW = IDX_W + 2;
  localparam logic signed [DW-1:0] RST_S = -DW'(RESET_DIST);
  localparam logic signed [DW-1:0] WIN_S = DW'(WIN_SLOTS);
  localparam logic signed [DW-1:0] LAT_S = DW'(SFU_LAT);
  localparam logic signed [DW-1:0] END_S = DW'(END_SLOTS);
  localparam logic signed [DW-1:0] ONE_S = DW'(1);

  logic signed [DW-1:0] br_rec, sw_rec, sfu_rec;
  logic signed [DW-1:0] cur_s, d_br, d_sw, d_sfu, d_end, sw_rec_nxt;
  logic                 is_sw, sw_open, thrend_nxt;

  assign cur_s = $signed({2'b00, cur_idx});
  assign d_br  = cur_s - br_rec;
  assign d_sw  = cur_s - sw_rec;
  assign d_sfu = cur_s - sfu_rec;

  assign in_br_win = d_br < WIN_S;
  assign in_sw_win = d_sw < WIN_S;
  assign sfu_close = d_sfu < LAT_S;
  assign sw_consec = thrsw && (d_sw == ONE_S);

  assign is_sw      = acc & is_alu & thrsw;
  assign sw_open    = is_sw & ~sw_consec;
  assign sw_rec_nxt = sw_open ? cur_s : sw_rec;
  assign thrend_nxt = thrend | (is_sw & last_found);
  assign d_end      = cur_s - sw_rec_nxt;
  assign end_win    = thrend_nxt && (d_end <= END_S);
  assign end_last   = thrend_nxt && (d_end == END_S);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx    <= '0;
      br_rec     <= RST_S;
      sw_rec     <= RST_S;
      sfu_rec    <= RST_S;
      last_found <= single_seg;
      thrend     <= 1'b0;
      sw_cnt     <= 2'd0;
      prev_vary  <= 1'b0;
      prev_u     <= 1'b0;
      prev_a     <= 1'b0;
    end else if (acc) begin
      cur_idx   <= cur_idx + 1'b1;
      prev_vary <= is_alu & vary;
      prev_u    <= is_alu & u_any;
      prev_a    <= is_alu & a_any;
      sw_rec    <= sw_rec_nxt;
      thrend    <= thrend_nxt;
      if (is_branch) br_rec <= cur_s;
      if (is_alu && sfu_any) sfu_rec <= cur_s;
      if (is_sw && sw_consec) last_found <= 1'b1;
      if (sw_open && sw_cnt != 2'd2) sw_cnt <= sw_cnt + 2'd1;
    end
  end

  // R8
  marker_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_found |=> last_found);

  // R9
  end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thrend |=> thrend);

  // R8
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cnt != 2'd0) |=> (sw_cnt >= $past(sw_cnt)));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(cur_idx));

endmodule

// File: rtl/ihc_rules.sv
`timescale 1ns/1ps
module ihc_rules
  import ihc_pkg::*;
(
  input  logic                 acc,
  input  logic                 is_branch,
  input  logic                 ld_vary,
  input  logic                 ld_unif,
  input  logic                 ld_unifa,
  input  logic                 u_any,
  input  logic                 a_any,
  input  logic                 sfu_any,
  input  logic                 multi_unit,
  input  logic                 r4_read,
  input  logic                 r4_write,
  input  logic                 thrsw,
  input  logic                 rf_write,
  input  logic                 tmu_wait,
  input  logic                 in_br_win,
  input  logic                 in_sw_win,
  input  logic                 sfu_close,
  input  logic                 sw_consec,
  input  logic                 prev_vary,
  input  logic                 prev_u,
  input  logic                 prev_a,
  input  logic                 last_found,
  input  logic                 thrend,
  input  logic                 end_win,
  input  logic                 end_last,
  input  logic [1:0]           sw_cnt,
  input  logic                 end_valid,
  output logic [NUM_RULES-1:0] viol
);
  logic alu_ok, br_ok;

  assign alu_ok = acc & ~is_branch;
  assign br_ok  = acc & is_branch;

  always_comb begin
    viol = '0;
    viol[int'(E_VARY_UNIF)-1]    = alu_ok & prev_vary & (ld_unif | ld_unifa);
    viol[int'(E_UNIF_MIX)-1]     = alu_ok & ((prev_u & a_any) | (prev_a & u_any));
    viol[int'(E_SFU_SWWIN)-1]    = alu_ok & in_sw_win & sfu_any;
    viol[int'(E_VARY_SWWIN)-1]   = alu_ok & in_sw_win & ld_vary;
    viol[int'(E_R4RD_EARLY)-1]   = alu_ok & sfu_close & r4_read;
    viol[int'(E_R4WR_EARLY)-1]   = alu_ok & sfu_close & r4_write;
    viol[int'(E_SFU_EARLY)-1]    = alu_ok & sfu_close & sfu_any;
    viol[int'(E_MULTI_UNIT)-1]   = alu_ok & multi_unit;
    viol[int'(E_SW_BRWIN)-1]     = alu_ok & thrsw & in_br_win;
    viol[int'(E_DOUBLE_MARK)-1]  = alu_ok & thrsw & sw_consec & last_found;
    viol[int'(E_SW_CLOSE)-1]     = alu_ok & thrsw & ~sw_consec & in_sw_win;
    viol[int'(E_RF_AFTER_END)-1] = alu_ok & end_win & rf_write;
    viol[int'(E_WAIT_LAST)-1]    = alu_ok & end_last & tmu_wait;
    viol[int'(E_BR_BRWIN)-1]     = br_ok & in_br_win;
    viol[int'(E_BR_SWWIN)-1]     = br_ok & in_sw_win;
    viol[int'(E_NO_MARK)-1]      = end_valid & (sw_cnt > 2'd1) & ~last_found;
    viol[int'(E_NO_END)-1]       = end_valid & ~thrend;
  end

endmodule

// File: rtl/ihc_report.sv
`timescale 1ns/1ps
module ihc_report
  import ihc_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RULES-1:0] viol,
  input  logic [IDX_W-1:0]     cur_idx,
  output logic                 err_flag,
  output logic [CODE_W-1:0]    err_code,
  output logic [IDX_W-1:0]     err_index
);
  logic [CODE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int k = NUM_RULES - 1; k >= 0; k--) begin
      if (viol[k]) pick = CODE_W'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      err_code  <= '0;
      err_index <= '0;
    end else if (!err_flag && |viol) begin
      err_flag  <= 1'b1;
      err_code  <= pick;
      err_index <= cur_idx;
    end
  end

  // R12
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R12
  first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> ($stable(err_code) && $stable(err_index)));

  // R12
  code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (err_code != '0));

  // R13
  clean_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |-> (err_code == '0 && err_index == '0));

endmodule

// File: rtl/instr_hazard_checker.sv
`timescale 1ns/1ps
module instr_hazard_checker
  import ihc_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_seg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              instr_is_branch,
  input  logic              add_active,
  input  logic              add_magic,
  input  logic [2:0]        add_kind,
  input  logic              mul_active,
  input  logic              mul_magic,
  input  logic [2:0]        mul_kind,
  input  logic              ld_unif,
  input  logic              ld_unif_rf,
  input  logic              ld_unifa,
  input  logic              ld_unifa_rf,
  input  logic              ld_vary,
  input  logic              ld_tex,
  input  logic              ld_tile,
  input  logic              ld_tile_u,
  input  logic              ld_vpm,
  input  logic              sig_wr_addr,
  input  logic              thr_switch,
  input  logic              r4_read,
  input  logic              r4_write,
  input  logic              tmu_wait,
  input  logic              end_valid,
  output logic              err_flag,
  output logic [4:0]        err_code,
  output logic [IDX_W-1:0]  err_index
);
  localparam int NUM_ALU = 2;

  logic                 acc, is_alu, u_any, a_any, rf_write;
  logic                 sfu_any, multi_unit;
  logic [IDX_W-1:0]     cur_idx;
  logic                 in_br_win, in_sw_win, sfu_close, sw_consec;
  logic                 prev_vary, prev_u, prev_a, last_found, thrend;
  logic                 end_win, end_last;
  logic [1:0]           sw_cnt;
  logic [NUM_RULES-1:0] viol;

  assign in_ready = rst_n;
  assign acc      = in_valid & in_ready;
  assign is_alu   = ~instr_is_branch;
  assign u_any    = ld_unif | ld_unif_rf;
  assign a_any    = ld_unifa | ld_unifa_rf;
  assign rf_write = (add_active & ~add_magic) | (mul_active & ~mul_magic) | sig_wr_addr;

  ihc_unit_count #(.NUM_ALU(NUM_ALU)) u_count (
    .op_act     ({mul_active, add_active}),
    .op_magic   ({mul_magic, add_magic}),
    .op_kind    ({mul_kind, add_kind}),
    .ld_tex     (ld_tex),
    .ld_tile    (ld_tile),
    .ld_tile_u  (ld_tile_u),
    .ld_vpm     (ld_vpm),
    .sfu_any    (sfu_any),
    .multi_unit (multi_unit)
  );

  ihc_track #(.IDX_W(IDX_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .single_seg (single_seg),
    .acc        (acc),
    .is_alu     (is_alu),
    .is_branch  (instr_is_branch),
    .thrsw      (thr_switch),
    .sfu_any    (sfu_any),
    .vary       (ld_vary),
    .u_any      (u_any),
    .a_any      (a_any),
    .cur_idx    (cur_idx),
    .in_br_win  (in_br_win),
    .in_sw_win  (in_sw_win),
    .sfu_close  (sfu_close),
    .sw_consec  (sw_consec),
    .prev_vary  (prev_vary),
    .prev_u     (prev_u),
    .prev_a     (prev_a),
    .last_found (last_found),
    .thrend     (thrend),
    .end_win    (end_win),
    .end_last   (end_last),
    .sw_cnt     (sw_cnt)
  );

  ihc_rules u_rules (
    .acc        (acc),
    .is_branch  (instr_is_branch),
    .ld_vary    (ld_vary),
    .ld_unif    (ld_unif),
    .ld_unifa   (ld_unifa),
    .u_any      (u_any),
    .a_any      (a_any),
    .sfu_any    (sfu_any),
    .multi_unit (multi_unit),
    .r4_read    (r4_read),
    .r4_write   (r4_write),
    .thrsw      (thr_switch),
    .rf_write   (rf_write),
    .tmu_wait   (tmu_wait),
    .in_br_win  (in_br_win),
    .in_sw_win  (in_sw_win),
    .sfu_close  (sfu_close),
    .sw_consec  (sw_consec),
    .prev_vary  (prev_vary),
    .prev_u     (prev_u),
    .prev_a     (prev_a),
    .last_found (last_found),
    .thrend     (thrend),
    .end_win    (end_win),
    .end_last   (end_last),
    .sw_cnt     (sw_cnt),
    .end_valid  (end_valid),
    .viol       (viol)
  );

  ihc_report #(.IDX_W(IDX_W)) u_report (
    .clk       (clk),
    .rst_n     (rst_n),
    .viol      (viol),
    .cur_idx   (cur_idx),
    .err_flag  (err_flag),
    .err_code  (err_code),
    .err_index (err_index)
  );

endmodule

// File: tb/instr_hazard_checker_bench.sv
`timescale 1ns/1ps
module instr_hazard_checker_bench;
  localparam int IDX_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_seg = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic instr_is_branch, add_active, add_magic, mul_active, mul_magic;
  logic [2:0] add_kind, mul_kind;
  logic ld_unif, ld_unif_rf, ld_unifa, ld_unifa_rf, ld_vary;
  logic ld_tex, ld_tile, ld_tile_u, ld_vpm, sig_wr_addr;
  logic thr_switch, r4_read, r4_write, tmu_wait, end_valid;
  logic err_flag;
  logic [4:0] err_code;
  logic [IDX_W-1:0] err_index;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  instr_hazard_checker #(.IDX_W(IDX_W)) u_instr_hazard_checker (
    .clk(clk), .rst_n(rst_n), .single_seg(single_seg),
    .in_valid(in_valid), .in_ready(in_ready),
    .instr_is_branch(instr_is_branch),
    .add_active(add_active), .add_magic(add_magic), .add_kind(add_kind),
    .mul_active(mul_active), .mul_magic(mul_magic), .mul_kind(mul_kind),
    .ld_unif(ld_unif), .ld_unif_rf(ld_unif_rf), .ld_unifa(ld_unifa),
    .ld_unifa_rf(ld_unifa_rf), .ld_vary(ld_vary), .ld_tex(ld_tex),
    .ld_tile(ld_tile), .ld_tile_u(ld_tile_u), .ld_vpm(ld_vpm),
    .sig_wr_addr(sig_wr_addr), .thr_switch(thr_switch),
    .r4_read(r4_read), .r4_write(r4_write), .tmu_wait(tmu_wait),
    .end_valid(end_valid),
    .err_flag(err_flag), .err_code(err_code), .err_index(err_index)
  );

  task automatic clr();
    instr_is_branch = 0; add_active = 0; add_magic = 0; add_kind = 0;
    mul_active = 0; mul_magic = 0; mul_kind = 0;
    ld_unif = 0; ld_unif_rf = 0; ld_unifa = 0; ld_unifa_rf = 0; ld_vary = 0;
    ld_tex = 0; ld_tile = 0; ld_tile_u = 0; ld_vpm = 0; sig_wr_addr = 0;
    thr_switch = 0; r4_read = 0; r4_write = 0; tmu_wait = 0; end_valid = 0;
  endtask

  task automatic do_reset(input logic ss);
    @(negedge clk);
    rst_n = 0; in_valid = 0; single_seg = ss; clr();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send();
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    clr();
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) send();
  endtask

  task automatic strobe_end();
    end_valid = 1;
    @(negedge clk);
    end_valid = 0;
  endtask

  task automatic sfu_op();
    add_active = 1; add_magic = 1; add_kind = 3'd2;
  endtask

  task automatic chk(input string req, input logic ef, input int ec, input int ei);
    n_chk++;
    if (err_flag !== ef || err_code !== 5'(ec) || err_index !== IDX_W'(ei)) begin
      n_err++;
      $display("FAIL %s: got flag=%0b code=%0d idx=%0d, expected flag=%0b code=%0d idx=%0d",
               req, err_flag, err_code, err_index, ef, ec, ei);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    clr();
    // R13 / R1: reset state and readiness
    do_reset(0);
    @(negedge clk);
    chk("R13 reset", 0, 0, 0);
    n_chk++;
    if (in_ready !== 1'b1) begin
      n_err++;
      $display("FAIL R1 ready: got %0b expected 1", in_ready);
    end

    // R4: special-function latency sweep, three follower kinds
    for (int f = 0; f < 3; f++) begin
      for (int g = 0; g < 4; g++) begin
        do_reset(0);
        sfu_op(); send();
        nops(g);
        if (f == 0) r4_read = 1; else if (f == 1) r4_write = 1; else sfu_op();
        send();
        if (g + 1 < 2) chk("R4 sfu latency", 1, 5 + f, g + 1);
        else           chk("R4 sfu latency", 0, 0, 0);
      end
    end

    // R6: special-function write / varying load in switch window
    for (int f = 0; f < 2; f++) begin
      for (int g = 0; g < 4; g++) begin
        do_reset(0);
        thr_switch = 1; send();
        nops(g);
        if (f == 0) sfu_op(); else ld_vary = 1;
        send();
        if (g + 1 < 3) chk("R6 switch window", 1, 3 + f, g + 1);
        else           chk("R6 switch window", 0, 0, 0);
      end
    end

    // R7: branch / switch windows
    for (int s = 0; s < 3; s++) begin
      for (int g = 0; g < 4; g++) begin
        int code;
        do_reset(0);
        if (s == 2) thr_switch = 1; else instr_is_branch = 1;
        send();
        nops(g);
        if (s == 0) thr_switch = 1; else instr_is_branch = 1;
        send();
        code = (s == 0) ? 9 : (s == 1) ? 14 : 15;
        if (g + 1 < 3) chk("R7 delay window", 1, code, g + 1);
        else           chk("R7 delay window", 0, 0, 0);
      end
    end

    // R8: second switch at growing distance
    for (int g = 0; g < 4; g++) begin
      do_reset(0);
      thr_switch = 1; send();
      nops(g);
      thr_switch = 1; send();
      if (g == 1) chk("R8 switch too close", 1, 11, 2);
      else        chk("R8 switch spacing", 0, 0, 0);
    end
    // R8: double marker
    do_reset(0);
    thr_switch = 1; send();
    thr_switch = 1; send();
    nops(2);
    thr_switch = 1; send();
    chk("R8 marker then end", 0, 0, 0);
    thr_switch = 1; send();
    chk("R8 double marker", 1, 10, 5);

    // R2: varying then uniform forms
    for (int k = 0; k < 4; k++) begin
      do_reset(0);
      ld_vary = 1; send();
      case (k)
        0: ld_unif = 1;
        1: ld_unifa = 1;
        2: ld_unif_rf = 1;
        default: ld_unifa_rf = 1;
      endcase
      send();
      if (k < 2) chk("R2 varying then uniform", 1, 1, 1);
      else       chk("R2 register-file form", 0, 0, 0);
    end
    do_reset(0);
    ld_vary = 1; send();
    nops(1);
    ld_unif = 1; send();
    chk("R2 gap", 0, 0, 0);

    // R3: all ordered pairs of uniform-type loads
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        do_reset(0);
        case (p)
          0: ld_unif = 1; 1: ld_unif_rf = 1; 2: ld_unifa = 1; default: ld_unifa_rf = 1;
        endcase
        send();
        case (q)
          0: ld_unif = 1; 1: ld_unif_rf = 1; 2: ld_unifa = 1; default: ld_unifa_rf = 1;
        endcase
        send();
        if ((p < 2) != (q < 2)) chk("R3 uniform mix", 1, 2, 1);
        else                    chk("R3 same type", 0, 0, 0);
      end
    end

    // R5: unit-count cross
    for (int ak = 0; ak < 6; ak++) begin
      for (int mk = 0; mk < 6; mk++) begin
        for (int ld = 0; ld < 5; ld++) begin
          int cnt;
          do_reset(0);
          add_active = 1; add_magic = 1; add_kind = 3'(ak);
          mul_active = 1; mul_magic = 1; mul_kind = 3'(mk);
          case (ld)
            1: ld_tex = 1; 2: ld_tile = 1; 3: ld_tile_u = 1; 4: ld_vpm = 1; default: ;
          endcase
          send();
          cnt = (ak != 0 ? 1 : 0) + (mk != 0 ? 1 : 0) + (ld != 0 ? 1 : 0);
          if (cnt > 1) chk("R5 unit count", 1, 8, 0);
          else         chk("R5 unit count", 0, 0, 0);
        end
      end
    end
    do_reset(0);
    add_active = 1; add_magic = 0; add_kind = 3'd2;
    mul_active = 1; mul_magic = 0; mul_kind = 3'd1;
    send();
    chk("R5 non-special slots", 0, 0, 0);

    // R9 / R11: end region in single-segment program
    for (int k = 0; k < 4; k++) begin
      do_reset(1);
      thr_switch = 1;
      if (k == 0) begin add_active = 1; add_magic = 0; end
      send();
      if (k > 0) begin
        nops(k - 1);
        add_active = 1; add_magic = 0; send();
      end
      if (k <= 2) chk("R9 register write after end", 1, 12, k);
      else        chk("R9 outside end region", 0, 0, 0);
    end
    do_reset(1);
    thr_switch = 1; send();
    sig_wr_addr = 1; send();
    chk("R9 address-writing signal", 1, 12, 1);
    for (int k = 1; k < 4; k++) begin
      do_reset(1);
      thr_switch = 1; send();
      nops(k - 1);
      tmu_wait = 1; send();
      if (k == 2) chk("R9 wait in final slot", 1, 13, 2);
      else        chk("R9 wait elsewhere", 0, 0, 0);
    end
    do_reset(0);
    thr_switch = 1; send();
    add_active = 1; add_magic = 0; send();
    chk("R11 multi-segment no end", 0, 0, 0);

    // R10 / R11: end strobe outcomes
    do_reset(1);
    nops(3);
    strobe_end();
    chk("R10 no end switch", 1, 17, 3);
    do_reset(0);
    thr_switch = 1; send();
    nops(2);
    thr_switch = 1; send();
    strobe_end();
    chk("R10 missing marker", 1, 16, 4);
    do_reset(0);
    thr_switch = 1; send();
    thr_switch = 1; send();
    nops(1);
    thr_switch = 1; send();
    strobe_end();
    chk("R10 well-formed program", 0, 0, 0);
    do_reset(1);
    thr_switch = 1; send();
    strobe_end();
    chk("R11 single segment end", 0, 0, 0);
    do_reset(0);
    thr_switch = 1; send();
    strobe_end();
    chk("R11 multi segment lone switch", 1, 17, 1);

    // R12: lowest code in one instruction, first error held
    do_reset(0);
    thr_switch = 1; send();
    sfu_op(); mul_active = 1; mul_magic = 1; mul_kind = 3'd1; send();
    chk("R12 lowest code wins", 1, 3, 1);
    instr_is_branch = 1; send();
    nops(2);
    chk("R12 first error held", 1, 3, 1);

    // R1: idle cycles carry no instruction
    do_reset(0);
    sfu_op(); send();
    for (int i = 0; i < 3; i++) begin
      r4_read = 1; sfu_op(); thr_switch = 1;
      @(negedge clk);
    end
    clr();
    chk("R1 idle cycles ignored", 0, 0, 0);
    r4_read = 1; send();
    chk("R1 index after idle", 1, 5, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule